// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

The block takes interrupt events from on-chip clients over a valid/ready handshake and stores each one in a circular buffer in memory. Every event becomes a fixed vector of four 32-bit words. The host drains the buffer by reading entries and then moving a read pointer forward. Both pointers are byte offsets into the ring, and the ring holds no unread entries when the two pointers match. The interrupt line is asserted while unread entries remain and interrupts are enabled. Any write to the read pointer re-evaluates the line, and that write is how the host re-arms it.

Software programs a set of registers: a control word, the ring base, the read and write pointers, and a 40-bit writeback address. If a new vector fills the last free slot, an overflow flag is raised inside the readable write-pointer value. The writer keeps going and overwrites old entries. When writeback is enabled, the updated write pointer is also copied to memory after each vector.

Top module: `irq_vec_ring`

## Requirements
- R1: Each accepted event produces four memory writes to consecutive word addresses, starting at (BASE<<8) plus the write pointer. The data words are:
  - word0 = {24'b0, src_id};
  - word1 = {4'b0, src_data};
  - word2 = {pasid, vmid, ring_id};
  - word3 = 0.
- R2: After each vector the write pointer advances by 16 modulo the ring size in bytes. The ring size in bytes is 4<<CTRL[12:8], with CTRL[12:8] limited to the range 2 to MAX_LOG2_DW. The WPTR register (offset 3) reads the pointer in bits [PTR_W-1:4].
- R3: Suppose overflow detection (CTRL bit 2) is set and a vector is accepted while (wptr+16) mod size equals the read pointer. Then bit 0 of the WPTR register becomes 1 once that vector is written. Writing continues and wraps over old entries.
- R4: The overflow flag stays at 1 across read-pointer writes. Only a CTRL write with bit 4 set clears it. That bit is a one-shot pulse.
- R5: With overflow detection off, filling the ring leaves WPTR bit 0 at 0.
- R6: With writeback on (CTRL bit 3), a fifth write follows each vector's four words. It goes to the address {WBHI[7:0], WBLO} (offsets 5 and 4), and its data is the new WPTR register value including the flag. With writeback off, no fifth write occurs.
- R7: irq_out equals (CTRL bit 1) AND (read pointer != write pointer). It is registered one cycle after the state that drives it, so a read-pointer write (offset 2) re-evaluates it.
- R8: With the ring disabled (CTRL bit 0 = 0), ev_ready is 0 and no memory writes start. In that state the host can write both pointers, and each reads back as written.
- R9: busy is 1 from the cycle after an event is accepted until the vector's last write (including writeback) is taken. It is also 1 whenever mem_wr_valid is 1.
- R10: While mem_wr_valid is 1 and mem_wr_ready is 0, mem_wr_valid, mem_wr_addr and mem_wr_data hold steady.
- R11: After reset every register reads 0, and irq_out, busy and ev_ready are 0. Register reads return the register at reg_addr one cycle after reg_addr is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event taken on this edge when valid |
| ev_src_id | input | 8 | Source identifier |
| ev_src_data | input | 28 | Source payload |
| ev_ring_id | input | 8 | Ring identifier |
| ev_vmid | input | 8 | Virtual machine identifier |
| ev_pasid | input | 16 | Process address space identifier |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | 40 | Byte address of the word |
| mem_wr_data | output | 32 | Word to write |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset: 0 CTRL, 1 BASE, 2 RPTR, 3 WPTR, 4 WBLO, 5 WBHI |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle latency |
| irq_out | output | 1 | Interrupt request |
| busy | output | 1 | Vector in flight to memory |

## Verification
The bench works the ring through its wrap point. A design that failed to mask the pointer there would write past the ring's end, and the scoreboard would see a wrong address. It fills the ring exactly once with overflow detection on and once with it off. This exposes a flag that is raised one slot early or late, raised while detection is disabled, or dropped by a read-pointer write. The bench also stalls the memory port on an irregular pattern and switches writeback on and off. A writer that advanced under backpressure, skipped the fifth write, or added one would make the scoreboard drop or gain an entry. Finally it holds an event at a disabled ring and checks that nothing is taken.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int VEC_DW   = 4;
  localparam int VEC_B    = VEC_DW * 4;
  localparam int AW       = 40;
  localparam int BASE_LSB = 8;

  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_BASE = 3'd1;
  localparam logic [2:0] OFS_RPTR = 3'd2;
  localparam logic [2:0] OFS_WPTR = 3'd3;
  localparam logic [2:0] OFS_WBLO = 3'd4;
  localparam logic [2:0] OFS_WBHI = 3'd5;

  typedef struct packed {
    logic [7:0]  src_id;
    logic [27:0] src_data;
    logic [7:0]  ring_id;
    logic [7:0]  vmid;
    logic [15:0] pasid;
  } ivr_event_t;

  typedef logic [VEC_DW-1:0][31:0] ivr_vec_t;

  typedef enum logic [1:0] {S_IDLE, S_VEC, S_WB} ivr_state_e;

  function automatic ivr_vec_t ivr_pack(ivr_event_t e);
    ivr_vec_t v;
    v[0] = {24'b0, e.src_id};
    v[1] = {4'b0, e.src_data};
    v[2] = {e.pasid, e.vmid, e.ring_id};
    v[3] = 32'b0;
    return v;
  endfunction
endpackage

// File: rtl/ivr_regs.sv
module ivr_regs
  import ivr_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int SZ_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [2:0]       addr,
  input  logic [31:0]      wdata,
  input  logic [31:0]      wptr_view,
  output logic [31:0]      rdata,
  output logic             ring_en,
  output logic             intr_en,
  output logic             ovf_det_en,
  output logic             wb_en,
  output logic             ovf_clr,
  output logic [SZ_W-1:0]  size_log2,
  output logic [31:0]      base,
  output logic [PTR_W-1:0] rptr,
  output logic [AW-1:0]    wb_addr,
  output logic             sw_wptr_we,
  output logic [PTR_W-1:0] sw_wptr_val
);
  localparam logic [PTR_W-1:0] ALIGN_M = ~PTR_W'(VEC_B - 1);

  logic [31:0] wb_lo_q;
  logic [7:0]  wb_hi_q;
  logic [31:0] ctrl_view;

  assign wb_addr   = {wb_hi_q, wb_lo_q};
  assign ctrl_view = {19'b0, size_log2, 4'b0, wb_en, ovf_det_en, intr_en, ring_en};

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_en     <= 1'b0;
      intr_en     <= 1'b0;
      ovf_det_en  <= 1'b0;
      wb_en       <= 1'b0;
      ovf_clr     <= 1'b0;
      size_log2   <= '0;
      base        <= '0;
      rptr        <= '0;
      wb_lo_q     <= '0;
      wb_hi_q     <= '0;
      sw_wptr_we  <= 1'b0;
      sw_wptr_val <= '0;
      rdata       <= '0;
    end else begin
      ovf_clr    <= 1'b0;
      sw_wptr_we <= 1'b0;
      if (we) begin
        case (addr)
          OFS_CTRL: begin
            ring_en    <= wdata[0];
            intr_en    <= wdata[1];
            ovf_det_en <= wdata[2];
            wb_en      <= wdata[3];
            ovf_clr    <= wdata[4];
            size_log2  <= wdata[8 +: SZ_W];
          end
          OFS_BASE: base <= wdata;
          OFS_RPTR: rptr <= wdata[PTR_W-1:0] & ALIGN_M;
          OFS_WPTR: begin
            if (!ring_en) begin
              sw_wptr_we  <= 1'b1;
              sw_wptr_val <= wdata[PTR_W-1:0] & ALIGN_M;
            end
          end
          OFS_WBLO: wb_lo_q <= wdata;
          OFS_WBHI: wb_hi_q <= wdata[7:0];
          default: ;
        endcase
      end
      case (addr)
        OFS_CTRL: rdata <= ctrl_view;
        OFS_BASE: rdata <= base;
        OFS_RPTR: rdata <= 32'(rptr);
        OFS_WPTR: rdata <= wptr_view;
        OFS_WBLO: rdata <= wb_lo_q;
        OFS_WBHI: rdata <= {24'b0, wb_hi_q};
        default:  rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ivr_engine.sv
module ivr_engine
  import ivr_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ring_en,
  input  logic             ovf_det_en,
  input  logic             wb_en,
  input  logic             ovf_clr,
  input  logic [PTR_W-1:0] ring_mask,
  input  logic [31:0]      base,
  input  logic [PTR_W-1:0] rptr,
  input  logic [AW-1:0]    wb_addr,
  input  logic             sw_wptr_we,
  input  logic [PTR_W-1:0] sw_wptr_val,
  input  logic             ev_valid,
  output logic             ev_ready,
  input  ivr_event_t       ev,
  output logic             mem_wr_valid,
  input  logic             mem_wr_ready,
  output logic [AW-1:0]    mem_wr_addr,
  output logic [31:0]      mem_wr_data,
  output logic [PTR_W-1:0] wptr,
  output logic             ovf,
  output logic             busy
);
  localparam int BEAT_W = $clog2(VEC_DW);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(VEC_DW - 1);

  ivr_state_e        state;
  logic [BEAT_W-1:0] beat;
  ivr_vec_t          vec_q;
  ivr_vec_t          vec_in;
  logic              hit_q;
  logic [PTR_W-1:0]  wptr_step;
  logic [AW-1:0]     ring_base;

  assign vec_in    = ivr_pack(ev);
  assign wptr_step = (wptr + PTR_W'(VEC_B)) & ring_mask;
  assign ring_base = {base, {BASE_LSB{1'b0}}};
  assign ev_ready  = (state == S_IDLE) && ring_en;
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      beat         <= '0;
      vec_q        <= '0;
      hit_q        <= 1'b0;
      wptr         <= '0;
      ovf          <= 1'b0;
      mem_wr_valid <= 1'b0;
      mem_wr_addr  <= '0;
      mem_wr_data  <= '0;
    end else begin
      if (ovf_clr) ovf <= 1'b0;
      case (state)
        S_IDLE: begin
          if (sw_wptr_we) wptr <= sw_wptr_val & ring_mask;
          if (ev_valid && ring_en) begin
            vec_q        <= vec_in;
            hit_q        <= ovf_det_en && (wptr_step == rptr);
            beat         <= '0;
            mem_wr_valid <= 1'b1;
            mem_wr_addr  <= ring_base + AW'(wptr);
            mem_wr_data  <= vec_in[0];
            state        <= S_VEC;
          end
        end
        S_VEC: begin
          if (mem_wr_ready) begin
            if (beat == LAST_BEAT) begin
              wptr <= wptr_step;
              if (hit_q) ovf <= 1'b1;
              if (wb_en) begin
                mem_wr_addr <= wb_addr;
                mem_wr_data <= 32'(wptr_step) | {31'b0, hit_q | (ovf & ~ovf_clr)};
                state       <= S_WB;
              end else begin
                mem_wr_valid <= 1'b0;
                state        <= S_IDLE;
              end
            end else begin
              beat        <= beat + 1'b1;
              mem_wr_addr <= mem_wr_addr + AW'(4);
              mem_wr_data <= vec_q[beat + 1'b1];
            end
          end
        end
        S_WB: begin
          if (mem_wr_ready) begin
            mem_wr_valid <= 1'b0;
            state        <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_vec_ring.sv
module irq_vec_ring
  import ivr_pkg::*;
#(
  parameter int MAX_LOG2_DW = 14,
  parameter int SZ_W        = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ev_valid,
  output logic        ev_ready,
  input  logic [7:0]  ev_src_id,
  input  logic [27:0] ev_src_data,
  input  logic [7:0]  ev_ring_id,
  input  logic [7:0]  ev_vmid,
  input  logic [15:0] ev_pasid,
  output logic        mem_wr_valid,
  input  logic        mem_wr_ready,
  output logic [39:0] mem_wr_addr,
  output logic [31:0] mem_wr_data,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_out,
  output logic        busy
);
  localparam int PTR_W   = MAX_LOG2_DW + 2;
  localparam int MIN_LB  = $clog2(VEC_B);

  logic             ring_en, intr_en, ovf_det_en, wb_en, ovf_clr;
  logic [SZ_W-1:0]  size_log2;
  logic [31:0]      base;
  logic [PTR_W-1:0] rptr, wptr, ring_mask, sw_wptr_val;
  logic [AW-1:0]    wb_addr;
  logic             sw_wptr_we, ovf;
  logic [31:0]      wptr_view;
  ivr_event_t       ev;
  int               lb;

  assign ev        = '{src_id: ev_src_id, src_data: ev_src_data, ring_id: ev_ring_id,
                       vmid: ev_vmid, pasid: ev_pasid};
  assign wptr_view = 32'(wptr) | {31'b0, ovf};

  always_comb begin
    lb = int'(size_log2) + 2;
    if (lb < MIN_LB) lb = MIN_LB;
    if (lb > PTR_W) lb = PTR_W;
    ring_mask = (PTR_W'(1) << lb) - PTR_W'(1);
  end

  ivr_regs #(.PTR_W(PTR_W), .SZ_W(SZ_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .wptr_view(wptr_view), .rdata(reg_rdata), .ring_en(ring_en), .intr_en(intr_en),
    .ovf_det_en(ovf_det_en), .wb_en(wb_en), .ovf_clr(ovf_clr), .size_log2(size_log2),
    .base(base), .rptr(rptr), .wb_addr(wb_addr), .sw_wptr_we(sw_wptr_we),
    .sw_wptr_val(sw_wptr_val)
  );

  ivr_engine #(.PTR_W(PTR_W)) u_engine (
    .clk(clk), .rst(rst), .ring_en(ring_en), .ovf_det_en(ovf_det_en), .wb_en(wb_en),
    .ovf_clr(ovf_clr), .ring_mask(ring_mask), .base(base), .rptr(rptr),
    .wb_addr(wb_addr), .sw_wptr_we(sw_wptr_we), .sw_wptr_val(sw_wptr_val),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev(ev), .mem_wr_valid(mem_wr_valid),
    .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .wptr(wptr), .ovf(ovf), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= intr_en && (rptr != wptr);
  end
endmodule

// File: rtl/ivr_checker.sv
module ivr_checker #(
  parameter int PTR_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ring_en,
  input logic             intr_en,
  input logic             ovf_clr,
  input logic             ovf,
  input logic [PTR_W-1:0] wptr,
  input logic [PTR_W-1:0] ring_mask,
  input logic             ev_ready,
  input logic             mem_wr_valid,
  input logic             mem_wr_ready,
  input logic [39:0]      mem_wr_addr,
  input logic [31:0]      mem_wr_data,
  input logic             irq_out,
  input logic             busy
);
  p_mem_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  p_no_take_r8: assert property (@(posedge clk) disable iff (rst)
    !ring_en |-> !ev_ready);

  p_irq_gate_r7: assert property (@(posedge clk) disable iff (rst)
    $past(!intr_en) |-> !irq_out);

  p_busy_r9: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> busy);

  p_wptr_range_r2: assert property (@(posedge clk) disable iff (rst)
    ((wptr & ~ring_mask) == '0) && (wptr[3:0] == 4'b0));

  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(ovf) && !$past(ovf_clr)) |-> ovf);
endmodule

bind irq_vec_ring ivr_checker #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst(rst), .ring_en(ring_en), .intr_en(intr_en), .ovf_clr(ovf_clr),
  .ovf(ovf), .wptr(wptr), .ring_mask(ring_mask), .ev_ready(ev_ready),
  .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
  .mem_wr_data(mem_wr_data), .irq_out(irq_out), .busy(busy)
);

// File: tb/irq_vec_ring_tb.sv
module irq_vec_ring_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [7:0]  ev_src_id = '0;
  logic [27:0] ev_src_data = '0;
  logic [7:0]  ev_ring_id = '0;
  logic [7:0]  ev_vmid = '0;
  logic [15:0] ev_pasid = '0;
  logic        mem_wr_valid;
  logic        mem_wr_ready = 1'b0;
  logic [39:0] mem_wr_addr;
  logic [31:0] mem_wr_data;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;
  logic        busy;

  always #2 clk = ~clk;

  irq_vec_ring u_dut (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_src_id(ev_src_id), .ev_src_data(ev_src_data), .ev_ring_id(ev_ring_id),
    .ev_vmid(ev_vmid), .ev_pasid(ev_pasid), .mem_wr_valid(mem_wr_valid),
    .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out), .busy(busy)
  );

  typedef struct packed { logic [39:0] addr; logic [31:0] data; } wr_t;
  wr_t exp_q[$];

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit stall_on = 1'b0;
  int cyc = 0;

  localparam logic [31:0] BASE_V = 32'h1234_5678;
  localparam logic [31:0] WBLO_V = 32'h0000_1000;
  localparam logic [7:0]  WBHI_V = 8'h05;
  localparam logic [39:0] RB     = {BASE_V, 8'h00};
  localparam logic [39:0] WBA    = {WBHI_V, WBLO_V};
  localparam int          MASK   = 63;

  int m_wptr = 0;
  int m_rptr = 0;
  bit m_ovf = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor; sets the stall pattern, then samples the handshake
  always @(negedge clk) begin
    cyc++;
    mem_wr_ready = stall_on ? ((cyc % 3) != 1) && ((cyc % 7) != 4) : 1'b1;
    if (!rst && mem_wr_valid && mem_wr_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected write", longint'(mem_wr_addr), 0);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        check(mem_wr_addr == e.addr, "R1 write address", longint'(mem_wr_addr), longint'(e.addr));
        check(mem_wr_data == e.data, "R1 write data", longint'(mem_wr_data), longint'(e.data));
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic send(input logic [7:0] sid, input logic [27:0] sdat, input logic [7:0] rid,
                      input logic [7:0] vm, input logic [15:0] pas, input bit det, input bit wb);
    int nxt;
    wr_t e;
    e.addr = RB + 40'(m_wptr);      e.data = {24'b0, sid};   exp_q.push_back(e);
    e.addr = RB + 40'(m_wptr + 4);  e.data = {4'b0, sdat};   exp_q.push_back(e);
    e.addr = RB + 40'(m_wptr + 8);  e.data = {pas, vm, rid}; exp_q.push_back(e);
    e.addr = RB + 40'(m_wptr + 12); e.data = 32'b0;          exp_q.push_back(e);
    nxt = (m_wptr + 16) & MASK;
    if (det && nxt == m_rptr) m_ovf = 1'b1;
    m_wptr = nxt;
    if (wb) begin
      e.addr = WBA; e.data = 32'(m_wptr) | {31'b0, m_ovf}; exp_q.push_back(e);
    end
    @(negedge clk);
    ev_valid = 1'b1; ev_src_id = sid; ev_src_data = sdat; ev_ring_id = rid;
    ev_vmid = vm; ev_pasid = pas;
    while (!ev_ready) @(negedge clk);
    @(negedge clk);
    ev_valid = 1'b0;
    check(busy == 1'b1, "R9 busy after accept", longint'(busy), 1);
    for (int t = 0; t < 500 && (exp_q.size() != 0 || busy); t++) @(negedge clk);
    check(exp_q.size() == 0, "R6 all writes seen", exp_q.size(), 0);
    check(busy == 1'b0, "R9 busy after drain", longint'(busy), 0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(irq_out == 1'b0, "R11 irq after reset", longint'(irq_out), 0);
    check(busy == 1'b0, "R11 busy after reset", longint'(busy), 0);
    check(ev_ready == 1'b0, "R11 ev_ready after reset", longint'(ev_ready), 0);
    rd(3'd0, v); check(v == 0, "R11 CTRL reset", v, 0);
    rd(3'd3, v); check(v == 0, "R11 WPTR reset", v, 0);
    rd(3'd2, v); check(v == 0, "R11 RPTR reset", v, 0);

    wr(3'd1, BASE_V);
    wr(3'd4, WBLO_V);
    wr(3'd5, {24'b0, WBHI_V});
    wr(3'd0, 32'h0000_040F);           // size 4 (64 B), wb, det, intr, ring
    rd(3'd0, v); check(v == 32'h0000_040F, "R2 CTRL readback", v, 32'h40F);

    // R1 first vector, R6 writeback
    send(8'hA5, 28'hABCDEF1, 8'h3C, 8'h07, 16'hBEEF, 1'b1, 1'b1);
    rd(3'd3, v); check(v == 32'h10, "R2 wptr after one vector", v, 32'h10);
    check(irq_out == 1'b1, "R7 irq with unread entry", longint'(irq_out), 1);
    wr(3'd2, 32'h10); m_rptr = 16;
    check(irq_out == 1'b0, "R7 irq cleared by rptr write", longint'(irq_out), 0);

    // R2 wrap, with memory backpressure (R10)
    stall_on = 1'b1;
    for (int i = 0; i < 3; i++)
      send(8'(i + 1), 28'(32'h0100_0000 + i), 8'(i), 8'(i * 2), 16'(i * 3 + 1), 1'b1, 1'b1);
    rd(3'd3, v); check(v == 32'h00, "R2 wptr wraps to zero", v, 0);
    rd(3'd3, v); check(v[0] == 1'b0, "R3 no flag before full", longint'(v[0]), 0);

    // R3 overflow on filling the last slot
    send(8'hFF, 28'hFFFFFFF, 8'hFF, 8'hFF, 16'hFFFF, 1'b1, 1'b1);
    rd(3'd3, v); check(v == 32'h11, "R3 overflow flag set", v, 32'h11);
    check(irq_out == 1'b0, "R7 irq equal pointers", longint'(irq_out), 0);

    // R4 sticky across rptr writes; cleared by control bit
    wr(3'd2, 32'h10);
    rd(3'd3, v); check(v == 32'h11, "R4 flag survives rptr write", v, 32'h11);
    wr(3'd0, 32'h0000_041F); m_ovf = 1'b0;
    rd(3'd3, v); check(v == 32'h10, "R4 flag cleared", v, 32'h10);
    rd(3'd0, v); check(v == 32'h0000_040F, "R4 clear bit reads zero", v, 32'h40F);

    // R5 detection off, R6 writeback off, R7 interrupt gate off
    wr(3'd0, 32'h0000_0401);
    for (int i = 0; i < 4; i++)
      send(8'(8'h40 + i), 28'(i), 8'h11, 8'h22, 16'h3344, 1'b0, 1'b0);
    rd(3'd3, v); check(v == 32'h10, "R5 no flag with detection off", v, 32'h10);
    send(8'h77, 28'h1234567, 8'h01, 8'h02, 16'h0003, 1'b0, 1'b0);
    @(negedge clk);
    check(irq_out == 1'b0, "R7 irq masked when disabled", longint'(irq_out), 0);
    rd(3'd3, v); check(v == 32'h20, "R2 wptr after fill", v, 32'h20);
    stall_on = 1'b0;

    // R8 disabled ring ignores events; pointers writable
    wr(3'd0, 32'h0000_0400);
    @(negedge clk);
    ev_valid = 1'b1; ev_src_id = 8'h99;
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      check(ev_ready == 1'b0 && busy == 1'b0, "R8 no accept while disabled",
            longint'({ev_ready, busy}), 0);
    end
    ev_valid = 1'b0;
    rd(3'd3, v); check(v == 32'h20, "R8 wptr untouched while disabled", v, 32'h20);
    wr(3'd3, 32'h0);
    wr(3'd2, 32'h0);
    rd(3'd3, v); check(v == 0, "R8 wptr written to zero", v, 0);
    rd(3'd2, v); check(v == 0, "R8 rptr written to zero", v, 0);
    check(exp_q.size() == 0, "R8 no stray writes", exp_q.size(), 0);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule